// File: doc/BRIEF.md
# DMA Bus Address Map Translator

This block sits between an 18-bit peripheral bus and a 22-bit main memory. Peripheral DMA masters issue byte addresses. The translator divides that address space into 32 windows of 8 KB each and, once the map is switched on, relocates each window to a base address held in a pair of relocation registers. A base may sit on any even byte address, so the physical address is the window base plus the 13-bit in-window offset. The result is a full 22-bit sum that wraps modulo 4 MB.

The topmost window holds the device register page. It is never relocated and is never presented as a memory access; the block flags it separately. While the external enable input is low, every other window passes straight through to the low 248 KB of memory with the upper physical bits cleared. A CPU-side word port reads and writes the relocation registers with byte-lane enables. The 32nd pair is decoded like the others, but it never feeds translation.

Top module: `dma_addr_map`

## Requirements
- R1: After a synchronous active-low reset, `xl_mem_valid`, `xl_io_page`, `xl_mapped` and `xl_phys` are zero and every relocation register reads zero.
- R2: With `map_en` low, a request on a window below the device page produces `xl_mem_valid`=1, `xl_mapped`=0 and `xl_phys` = the 18-bit address zero-extended, on the clock edge after the one that samples `dma_valid`.
- R3: With `map_en` high, a request on window `dma_addr[17:13]` below 31 produces `xl_mem_valid`=1, `xl_mapped`=1 and `xl_phys` = base + `dma_addr[12:0]`, one edge after sampling. The base is {high register[5:0], low register[15:1], 0}.
- R4: A request with `dma_addr[17:13]`=31 (octal 760000–777777) produces `xl_io_page`=1 and `xl_mem_valid`=0 whether `map_en` is high or low. `xl_io_page` and `xl_mem_valid` are never high together.
- R5: The register port hits only even byte addresses from octal 770200 to 770376. Pair n's low register is at 770200+4n and its high register is at 770202+4n. A read that misses returns 0 and does not set `reg_hit`.
- R6: Unimplemented bits read as zero: bit 0 of every low register and bits 15:6 of every high register.
- R7: A write changes only the byte lanes whose `reg_be` bit is set: bit 0 covers data bits 7:0 and bit 1 covers bits 15:8.
- R8: The pair-31 registers (octal 770374/770376) keep written values and read them back, but they never affect any translation.
- R9: A register write is used by a translation whose request is sampled on the next edge. A request sampled on the same edge as the write uses the old value.
- R10: The relocated sum wraps modulo 2^22.
- R11: An edge with `dma_valid` low leaves `xl_mem_valid`, `xl_io_page` and `xl_mapped` low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_en | input | 1 | Enables relocation through the map |
| dma_valid | input | 1 | DMA address strobe |
| dma_addr | input | 18 | DMA byte address |
| xl_mem_valid | output | 1 | Registered: memory access to `xl_phys` |
| xl_io_page | output | 1 | Registered: request fell in the device page, not forwarded |
| xl_mapped | output | 1 | Registered: address came through a relocation register |
| xl_phys | output | 22 | Registered physical byte address |
| reg_sel | input | 1 | Register port select |
| reg_we | input | 1 | Register write strobe |
| reg_be | input | 2 | Byte-lane enables for writes |
| reg_addr | input | 18 | Register port byte address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| reg_hit | output | 1 | Address decoded to a relocation register |

## Verification
Translation results appear one clock after the edge that samples `dma_valid`. The bench drives each request at a falling edge and samples the outputs at the next falling edge, after exactly one rising edge has passed. Register reads are combinational, so they are checked a short delay after the address settles within the same low phase. Writes land on the rising edge that follows the drive. The write-to-use ordering of R9 is checked by issuing a write and a request on the same edge, and then a request on the next edge, and comparing the two results.

// File: rtl/dma_map_pkg.sv
// Package: shared sizes and helpers for the DMA address map translator.
// Assumes a 16-bit register word and 8-bit byte lanes.
package dma_map_pkg;
    parameter int BUS_AW  = 18;   // peripheral byte address width
    parameter int PHYS_AW = 22;   // main-memory byte address width
    parameter int OFF_W   = 13;   // in-window offset width (8 KB)
    parameter int WORD_W  = 16;   // register word width
    parameter logic [17:0] MAP_REG_BASE = 18'o770200;

    // Expand byte enables into a per-bit mask.
    function automatic logic [WORD_W-1:0] lane_mask(input logic [WORD_W/8-1:0] be);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++) m[i] = be[i/8];
        return m;
    endfunction
endpackage

// File: rtl/map_reg_decode.sv
// Module: decodes a register-port byte address into pair index and half.
// Assumes the register window is aligned to its own size (4 bytes per pair).
module map_reg_decode #(
    parameter int          BUS_AW   = 18,
    parameter int          SLOT_W   = 5,
    parameter logic [17:0] REG_BASE = 18'o770200
) (
    input  logic              sel,
    input  logic [BUS_AW-1:0] addr,
    output logic              hit,
    output logic [SLOT_W-1:0] slot,
    output logic              hi_half
);
    localparam int TAG_LSB = SLOT_W + 2;

    // Compare the window tag, reject odd addresses, split index and half.
    always_comb begin
        hit     = sel && (addr[BUS_AW-1:TAG_LSB] == REG_BASE[BUS_AW-1:TAG_LSB]) && !addr[0];
        slot    = addr[TAG_LSB-1:2];
        hi_half = addr[1];
    end
endmodule

// File: rtl/map_regfile.sv
// Module: relocation register pairs with byte-lane writes and masked readback.
// Assumes one write per cycle; only implemented bits are stored.
module map_regfile #(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = 5,
    parameter int WORD_W    = 16,
    parameter int PHYS_AW   = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [SLOT_W-1:0] slot,
    input  logic              hi_half,
    input  logic [WORD_W/8-1:0] be,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic [PHYS_AW-1:0] slot_base [NUM_SLOTS]
);
    localparam int HI_W = PHYS_AW - WORD_W;

    logic [WORD_W-1:1] lo_q [NUM_SLOTS];
    logic [HI_W-1:0]   hi_q [NUM_SLOTS];
    logic [WORD_W-1:0] wmask;

    // Per-bit write mask from the byte enables.
    always_comb wmask = dma_map_pkg::lane_mask(be);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        // Hold one pair; update only the enabled lanes of the addressed half.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q[s] <= '0;
                hi_q[s] <= '0;
            end else if (wr && slot == SLOT_W'(s)) begin
                if (hi_half)
                    hi_q[s] <= (hi_q[s] & ~wmask[HI_W-1:0]) | (wdata[HI_W-1:0] & wmask[HI_W-1:0]);
                else
                    lo_q[s] <= (lo_q[s] & ~wmask[WORD_W-1:1]) | (wdata[WORD_W-1:1] & wmask[WORD_W-1:1]);
            end
        end

        // Assemble the even physical base for this window.
        always_comb slot_base[s] = {hi_q[s], lo_q[s], 1'b0};
    end

    // Read mux: unimplemented bits return zero, misses return zero.
    always_comb begin
        rdata = '0;
        if (rd) begin
            if (hi_half) rdata = WORD_W'(hi_q[slot]);
            else         rdata = {lo_q[slot], 1'b0};
        end
    end
endmodule

// File: rtl/addr_xlate.sv
// Module: translates a DMA address and registers the result one cycle later.
// Assumes the last window is the device page and is never relocated.
module addr_xlate #(
    parameter int BUS_AW    = 18,
    parameter int PHYS_AW   = 22,
    parameter int OFF_W     = 13,
    parameter int NUM_SLOTS = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               map_en,
    input  logic               dma_valid,
    input  logic [BUS_AW-1:0]  dma_addr,
    input  logic [PHYS_AW-1:0] slot_base [NUM_SLOTS],
    output logic               mem_valid,
    output logic               io_page,
    output logic               mapped,
    output logic [PHYS_AW-1:0] phys
);
    localparam int BLK_W = BUS_AW - OFF_W;
    localparam logic [BLK_W-1:0] IO_BLK = BLK_W'(NUM_SLOTS - 1);

    logic [BLK_W-1:0]   blk;
    logic               in_io;
    logic [PHYS_AW-1:0] reloc;
    logic [PHYS_AW-1:0] direct;

    // Window select, device-page detect, relocated sum and pass-through.
    always_comb begin
        blk    = dma_addr[BUS_AW-1:OFF_W];
        in_io  = (blk == IO_BLK);
        reloc  = slot_base[blk] + PHYS_AW'(dma_addr[OFF_W-1:0]);
        direct = PHYS_AW'(dma_addr);
    end

    // Result register: one cycle after the sampled strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_valid <= 1'b0;
            io_page   <= 1'b0;
            mapped    <= 1'b0;
            phys      <= '0;
        end else begin
            mem_valid <= dma_valid && !in_io;
            io_page   <= dma_valid && in_io;
            mapped    <= dma_valid && !in_io && map_en;
            phys      <= (dma_valid && !in_io) ? (map_en ? reloc : direct) : '0;
        end
    end
endmodule

// File: rtl/dma_addr_map.sv
// Module: top of the DMA address map translator.
// Assumes the enable comes from a register elsewhere; reads are combinational.
module dma_addr_map #(
    parameter int          BUS_AW   = dma_map_pkg::BUS_AW,
    parameter int          PHYS_AW  = dma_map_pkg::PHYS_AW,
    parameter int          OFF_W    = dma_map_pkg::OFF_W,
    parameter int          WORD_W   = dma_map_pkg::WORD_W,
    parameter logic [17:0] REG_BASE = dma_map_pkg::MAP_REG_BASE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               map_en,
    input  logic               dma_valid,
    input  logic [BUS_AW-1:0]  dma_addr,
    output logic               xl_mem_valid,
    output logic               xl_io_page,
    output logic               xl_mapped,
    output logic [PHYS_AW-1:0] xl_phys,
    input  logic               reg_sel,
    input  logic               reg_we,
    input  logic [WORD_W/8-1:0] reg_be,
    input  logic [BUS_AW-1:0]  reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic               reg_hit
);
    localparam int SLOT_W    = BUS_AW - OFF_W;
    localparam int NUM_SLOTS = 1 << SLOT_W;

    logic [SLOT_W-1:0]  dec_slot;
    logic               dec_hi;
    logic [PHYS_AW-1:0] bases [NUM_SLOTS];

    map_reg_decode #(.BUS_AW(BUS_AW), .SLOT_W(SLOT_W), .REG_BASE(REG_BASE)) u_dec (
        .sel(reg_sel), .addr(reg_addr), .hit(reg_hit), .slot(dec_slot), .hi_half(dec_hi)
    );

    map_regfile #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .WORD_W(WORD_W), .PHYS_AW(PHYS_AW)) u_rf (
        .clk(clk), .rst_n(rst_n), .wr(reg_hit && reg_we), .rd(reg_hit),
        .slot(dec_slot), .hi_half(dec_hi), .be(reg_be), .wdata(reg_wdata),
        .rdata(reg_rdata), .slot_base(bases)
    );

    addr_xlate #(.BUS_AW(BUS_AW), .PHYS_AW(PHYS_AW), .OFF_W(OFF_W), .NUM_SLOTS(NUM_SLOTS)) u_xl (
        .clk(clk), .rst_n(rst_n), .map_en(map_en), .dma_valid(dma_valid), .dma_addr(dma_addr),
        .slot_base(bases), .mem_valid(xl_mem_valid), .io_page(xl_io_page),
        .mapped(xl_mapped), .phys(xl_phys)
    );
endmodule

// File: rtl/dma_addr_map_chk.sv
// Module: protocol checker for dma_addr_map, attached by bind.
// Assumes the default 18/22/13/16 geometry.
module dma_addr_map_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        map_en,
    input logic        dma_valid,
    input logic [17:0] dma_addr,
    input logic        xl_mem_valid,
    input logic        xl_io_page,
    input logic        xl_mapped,
    input logic [21:0] xl_phys,
    input logic        reg_hit,
    input logic        reg_addr1,
    input logic [15:0] reg_rdata
);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_valid |=> (!xl_mem_valid && !xl_io_page && !xl_mapped));
    // R4
    io_page_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && dma_addr[17:13] == 5'd31) |=> (xl_io_page && !xl_mem_valid));
    // R4
    io_mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(xl_io_page && xl_mem_valid));
    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && !map_en && dma_addr[17:13] != 5'd31)
        |=> (xl_mem_valid && !xl_mapped && xl_phys == {4'b0, $past(dma_addr)}));
    // R3
    mapped_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && map_en && dma_addr[17:13] != 5'd31) |=> (xl_mem_valid && xl_mapped));
    // R5
    miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_hit |-> reg_rdata == 16'h0);
    // R6
    lo_bit0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_hit && !reg_addr1) |-> !reg_rdata[0]);
    // R6
    hi_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_hit && reg_addr1) |-> reg_rdata[15:6] == 10'h0);
endmodule

bind dma_addr_map dma_addr_map_chk u_chk (
    .clk(clk), .rst_n(rst_n), .map_en(map_en), .dma_valid(dma_valid), .dma_addr(dma_addr),
    .xl_mem_valid(xl_mem_valid), .xl_io_page(xl_io_page), .xl_mapped(xl_mapped),
    .xl_phys(xl_phys), .reg_hit(reg_hit), .reg_addr1(reg_addr[1]), .reg_rdata(reg_rdata)
);

// File: tb/sim_dma_addr_map.sv
module sim_dma_addr_map;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_en = 1'b0;
    logic        dma_valid = 1'b0;
    logic [17:0] dma_addr = '0;
    logic        xl_mem_valid, xl_io_page, xl_mapped;
    logic [21:0] xl_phys;
    logic        reg_sel = 1'b0, reg_we = 1'b0;
    logic [1:0]  reg_be = 2'b00;
    logic [17:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        reg_hit;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dma_addr_map u0 (
        .clk(clk), .rst_n(rst_n), .map_en(map_en), .dma_valid(dma_valid), .dma_addr(dma_addr),
        .xl_mem_valid(xl_mem_valid), .xl_io_page(xl_io_page), .xl_mapped(xl_mapped),
        .xl_phys(xl_phys), .reg_sel(reg_sel), .reg_we(reg_we), .reg_be(reg_be),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_hit(reg_hit)
    );

    // kind: 1 = pass-through memory, 2 = relocated memory, 3 = device page
    // fields: en[42], addr[41:24], kind[23:22], phys[21:0]
    localparam int NV = 11;
    localparam logic [42:0] VEC [NV] = '{
        {1'b0, 18'h00100, 2'd1, 22'h000100},   // R2
        {1'b0, 18'h3DFFE, 2'd1, 22'h03DFFE},   // R2 top of low 248 KB
        {1'b0, 18'h3E000, 2'd3, 22'h000000},   // R4 disabled
        {1'b1, 18'h00000, 2'd2, 22'h123456},   // R3 unaligned base
        {1'b1, 18'h01FFE, 2'd2, 22'h125454},   // R3
        {1'b1, 18'h02000, 2'd2, 22'h3FFFFE},   // R3
        {1'b1, 18'h02010, 2'd2, 22'h00000E},   // R10 wrap
        {1'b1, 18'h0A123, 2'd2, 22'h000BCD},   // R3
        {1'b1, 18'h3DFFF, 2'd2, 22'h201FFF},   // R3 window 30
        {1'b1, 18'h3E004, 2'd3, 22'h000000},   // R4 R8 enabled
        {1'b1, 18'h04006, 2'd2, 22'h000006}    // R3 unwritten pair
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [17:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_be = be; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0; reg_be = 2'b00;
    endtask

    task automatic rd_reg(input string req, input logic [17:0] a, input logic exp_hit,
                          input logic [15:0] exp_d);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1;
        chk(req, {31'b0, reg_hit}, {31'b0, exp_hit});
        chk(req, {16'b0, reg_rdata}, {16'b0, exp_d});
        reg_sel = 1'b0;
    endtask

    task automatic xlate(input string req, input logic en, input logic [17:0] a,
                         input logic [1:0] kind, input logic [21:0] ph);
        @(negedge clk);
        map_en = en; dma_valid = 1'b1; dma_addr = a;
        @(negedge clk);
        dma_valid = 1'b0;
        chk(req, {31'b0, xl_mem_valid}, {31'b0, kind != 2'd3});
        chk(req, {31'b0, xl_io_page}, {31'b0, kind == 2'd3});
        chk(req, {31'b0, xl_mapped}, {31'b0, kind == 2'd2});
        if (kind != 2'd3) chk(req, {10'b0, xl_phys}, {10'b0, ph});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 mem_valid", {31'b0, xl_mem_valid}, 32'd0);
        chk("R1 io_page", {31'b0, xl_io_page}, 32'd0);
        chk("R1 phys", {10'b0, xl_phys}, 32'd0);
        rd_reg("R1 lo0", 18'o770200, 1'b1, 16'h0000);
        rd_reg("R1 hi0", 18'o770202, 1'b1, 16'h0000);

        // Program bases (R5 pair layout)
        wr_reg(18'o770200, 2'b11, 16'h3456); wr_reg(18'o770202, 2'b11, 16'h0012);
        wr_reg(18'o770204, 2'b11, 16'hFFFE); wr_reg(18'o770206, 2'b11, 16'h003F);
        wr_reg(18'o770224, 2'b11, 16'h0AAA); wr_reg(18'o770226, 2'b11, 16'h0000);
        wr_reg(18'o770370, 2'b11, 16'h0000); wr_reg(18'o770372, 2'b11, 16'h0020);
        wr_reg(18'o770374, 2'b11, 16'h5554); wr_reg(18'o770376, 2'b11, 16'h0015); // R8

        for (int i = 0; i < NV; i++)
            xlate("R2/R3/R4/R10 vector", VEC[i][42], VEC[i][41:24], VEC[i][23:22], VEC[i][21:0]);

        // R5 decode edges
        rd_reg("R5 below window", 18'o770176, 1'b0, 16'h0000);
        rd_reg("R5 above window", 18'o770400, 1'b0, 16'h0000);
        rd_reg("R5 odd address", 18'o770201, 1'b0, 16'h0000);
        rd_reg("R5 hi pair0", 18'o770202, 1'b1, 16'h0012);
        // R8 pair 31 readback
        rd_reg("R8 lo31", 18'o770374, 1'b1, 16'h5554);
        rd_reg("R8 hi31", 18'o770376, 1'b1, 16'h0015);
        // R6 masking
        wr_reg(18'o770214, 2'b11, 16'hFFFF); rd_reg("R6 lo mask", 18'o770214, 1'b1, 16'hFFFE);
        wr_reg(18'o770216, 2'b11, 16'hFFFF); rd_reg("R6 hi mask", 18'o770216, 1'b1, 16'h003F);
        // R7 byte lanes
        wr_reg(18'o770220, 2'b01, 16'h1234); rd_reg("R7 low lane", 18'o770220, 1'b1, 16'h0034);
        wr_reg(18'o770220, 2'b10, 16'hAB00); rd_reg("R7 high lane", 18'o770220, 1'b1, 16'hAB34);
        wr_reg(18'o770222, 2'b10, 16'hFFFF); rd_reg("R7 hi upper lane", 18'o770222, 1'b1, 16'h0000);

        // R9 same-edge write uses old base, next edge uses new
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_be = 2'b11; reg_addr = 18'o770230; reg_wdata = 16'h0100;
        map_en = 1'b1; dma_valid = 1'b1; dma_addr = 18'h0C000;
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0;
        chk("R9 old base", {10'b0, xl_phys}, 32'h000000);
        dma_addr = 18'h0C000;
        @(negedge clk);
        dma_valid = 1'b0;
        chk("R9 new base", {10'b0, xl_phys}, 32'h000100);

        // R11 idle cycle
        @(negedge clk);
        chk("R11 idle mem_valid", {31'b0, xl_mem_valid}, 32'd0);
        chk("R11 idle mapped", {31'b0, xl_mapped}, 32'd0);

        // R1 reset again clears outputs and registers
        xlate("R3 before reset", 1'b1, 18'h00000, 2'd2, 22'h123456);
        @(negedge clk); rst_n = 1'b0; dma_valid = 1'b1;
        @(negedge clk); rst_n = 1'b1; dma_valid = 1'b0;
        chk("R1 reset mem_valid", {31'b0, xl_mem_valid}, 32'd0);
        rd_reg("R1 reset lo0", 18'o770200, 1'b1, 16'h0000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule